// File: doc/BRIEF.md
# Bus-Synchronizing Wait-State Generator

This block sits between a fast CPU and the slow memory and peripherals of a 1 MHz-class 8-bit computer that has been retrofitted with a faster processor. Every output is derived from one master oscillator (nominally 14.31818 MHz). The master clock divided by two becomes the CPU clock. The master clock divided by fourteen becomes a free-running two-phase legacy clock. The legacy clock has two non-overlapping phases, because the fast CPU does not drive them and the old interface chips still need them.

Each CPU bus cycle presents a bank byte, a 16-bit address and a valid-address flag. The following accesses are slow:
- the I/O window of bank zero;
- the ROM window of bank zero;
- all RAM, when the slow-RAM configuration input is set.

For a slow access the block pulls the CPU's ready line low. It does not touch the CPU clock. The access is placed on the legacy bus during the next high phase of the legacy PHI2. Ready returns high when that phase ends, and the CPU then finishes the cycle. Other accesses complete with no wait state.

The CPU model used here works as follows. A CPU cycle begins at a falling edge of the CPU clock and ends at the next falling edge. The CPU samples ready at the rising edge in the middle of the cycle. If ready was low, the CPU repeats the cycle with the same address.

Top module: `wsg_top`

## Requirements
- R1: The CPU clock is the master clock divided by two. It is low while reset is active. After `rst_n` rises, the CPU clock first goes high on the third master edge and then toggles on every master edge.
- R2: The legacy clock has a period of 14 master cycles. A legacy phase index starts at 0 and advances by one on each master edge from the third edge after `rst_n` rises, wrapping from 13 to 0. PHI1 is high at indices 1 to 6 and PHI2 is high at indices 8 to 13, so the two phases are never high together. The CPU clock is high at odd indices.
- R3: Only bank bits [1:0] are decoded, so bank values above 3 alias banks 0 to 3. In bank 0, the addresses 0x9000–0x9FFF (I/O) and 0xC000–0xFFFF (ROM) are slow. Every other address in every bank is RAM.
- R4: With `cfg_slow_ram` at 0, RAM accesses keep `cpu_rdy` high and complete at the next CPU clock falling edge. With `cfg_slow_ram` at 1, every valid access is slow.
- R5: A cycle with `cpu_vda` low is never stretched, whatever its address.
- R6: A slow access holds `cpu_rdy` low from the start of its cycle. `leg_cyc` rises with the first PHI2 rising edge that comes strictly after the address appeared, and stays high exactly for that PHI2 high phase.
- R7: `cpu_rdy` returns high on the master edge where PHI2 falls. The CPU cycle therefore ends at the CPU clock falling edge two master cycles later.
- R8: `cpu_rdy` changes only while the CPU clock is low.
- R9: While reset is active, `cpu_clk`, `leg_phi1`, `leg_phi2` and `leg_cyc` are 0, and `cpu_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slow_ram | input | 1 | Treat all RAM as slow |
| cpu_bank | input | 8 | Bank byte of the current bus cycle |
| cpu_addr | input | 16 | Address of the current bus cycle |
| cpu_vda | input | 1 | Current cycle carries a valid address |
| cpu_clk | output | 1 | CPU clock, master divided by two |
| leg_phi1 | output | 1 | Legacy clock phase 1 |
| leg_phi2 | output | 1 | Legacy clock phase 2 |
| cpu_rdy | output | 1 | CPU ready, low inserts wait states |
| leg_cyc | output | 1 | A stretched access occupies the legacy bus |

## Verification
The assertions check the following on every cycle:
- the CPU clock toggles continuously;
- PHI1 and PHI2 are never high together;
- `leg_cyc` is high only inside a PHI2 high phase and starts with it;
- ready is released exactly as PHI2 falls;
- ready never moves while the CPU clock is high;
- an invalid-address cycle is never held.

Only the bench scenarios can show the rest: the address-window decode at each boundary, the bank aliasing, the slow-RAM option, and the wait length. The wait length depends on the legacy phase at which the access arrives, including an arrival on the very edge where PHI2 rises, which costs a whole extra legacy period.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // Wait-state sequencer states
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,  // no stretched access in flight
    WS_LEG  = 2'd1,  // access occupies the legacy PHI2 phase
    WS_REL  = 2'd2   // ready released, CPU finishing its cycle
  } ws_state_t;

endpackage

// File: rtl/wsg_clkgen.sv
module wsg_clkgen #(
  parameter int DIV = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic cpu_clk,
  output logic phi1,
  output logic phi2,
  output logic cpu_fall,
  output logic ph2_rise,
  output logic ph2_fall
);

  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
  localparam logic [CW-1:0] P1_ON  = CW'(1);
  localparam logic [CW-1:0] P1_OFF = CW'(HALF - 1);
  localparam logic [CW-1:0] P2_ON  = CW'(HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cpu_d, phi1_d, phi2_d;

  // Phase index: one full legacy period per wrap
  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
    cpu_d    = cnt_d[0];
    phi1_d   = (cnt_d >= P1_ON) && (cnt_d <= P1_OFF);
    phi2_d   = (cnt_d >= P2_ON);
    // Event strobes for the master edge about to happen
    cpu_fall = ~cnt_d[0];
    ph2_rise = (cnt_d == P2_ON);
    ph2_fall = (cnt_d == '0);
  end

  // Registered clock outputs, free of decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cpu_clk <= 1'b0;
      phi1    <= 1'b0;
      phi2    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cpu_clk <= cpu_d;
      phi1    <= phi1_d;
      phi2    <= phi2_d;
    end
  end

endmodule

// File: rtl/wsg_decode.sv
module wsg_decode #(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16,
  parameter int NBANK  = 4,
  parameter logic [ADDR_W-1:0] IO_LO  = 16'h9000,
  parameter logic [ADDR_W-1:0] IO_HI  = 16'h9FFF,
  parameter logic [ADDR_W-1:0] ROM_LO = 16'hC000
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vda,
  input  logic              slow_ram,
  output logic              slow_req
);

  localparam int BSEL_W = $clog2(NBANK);

  logic in_home, in_io, in_rom;

  // Upper bank bits are ignored: higher banks alias the low ones
  always_comb begin
    in_home  = (bank[BSEL_W-1:0] == '0);
    in_io    = (addr >= IO_LO) && (addr <= IO_HI);
    in_rom   = (addr >= ROM_LO);
    slow_req = vda && (slow_ram || (in_home && (in_io || in_rom)));
  end

endmodule

// File: rtl/wsg_wait.sv
module wsg_wait
  import wsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slow_req,
  input  logic cpu_fall,
  input  logic ph2_rise,
  input  logic ph2_fall,
  output logic rdy,
  output logic leg_cyc
);

  ws_state_t state_q, state_d;
  logic      state_en;

  // Next state: every move lands on a CPU-clock falling edge
  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    unique case (state_q)
      WS_IDLE: if (slow_req && ph2_rise) begin
        state_d  = WS_LEG;
        state_en = 1'b1;
      end
      WS_LEG: if (ph2_fall) begin
        state_d  = WS_REL;
        state_en = 1'b1;
      end
      WS_REL: if (cpu_fall) begin
        state_d  = WS_IDLE;
        state_en = 1'b1;
      end
      default: begin
        state_d  = WS_IDLE;
        state_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= WS_IDLE;
    else if (state_en) state_q <= state_d;
  end

  // Ready drops with a slow address and rises once the legacy phase ends
  always_comb begin
    rdy     = ~(slow_req && (state_q != WS_REL));
    leg_cyc = (state_q == WS_LEG);
  end

endmodule

// File: rtl/wsg_top.sv
module wsg_top #(
  parameter int DIV    = 14,
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16,
  parameter int NBANK  = 4,
  parameter logic [ADDR_W-1:0] IO_LO  = 16'h9000,
  parameter logic [ADDR_W-1:0] IO_HI  = 16'h9FFF,
  parameter logic [ADDR_W-1:0] ROM_LO = 16'hC000
) (
  input  logic              clk_mst,
  input  logic              rst_n,
  input  logic              cfg_slow_ram,
  input  logic [BANK_W-1:0] cpu_bank,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_vda,
  output logic              cpu_clk,
  output logic              leg_phi1,
  output logic              leg_phi2,
  output logic              cpu_rdy,
  output logic              leg_cyc
);

  logic [1:0] sync_q;
  logic       rst_sync;
  logic       cpu_fall, ph2_rise, ph2_fall, slow_req;

  // Reset asserts at once, releases after two master edges
  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync = sync_q[1];

  wsg_clkgen #(.DIV(DIV)) u_clk (
    .clk      (clk_mst),
    .rst_n    (rst_sync),
    .cpu_clk  (cpu_clk),
    .phi1     (leg_phi1),
    .phi2     (leg_phi2),
    .cpu_fall (cpu_fall),
    .ph2_rise (ph2_rise),
    .ph2_fall (ph2_fall)
  );

  wsg_decode #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W),
    .NBANK  (NBANK),
    .IO_LO  (IO_LO),
    .IO_HI  (IO_HI),
    .ROM_LO (ROM_LO)
  ) u_dec (
    .bank     (cpu_bank),
    .addr     (cpu_addr),
    .vda      (cpu_vda),
    .slow_ram (cfg_slow_ram),
    .slow_req (slow_req)
  );

  wsg_wait u_wait (
    .clk      (clk_mst),
    .rst_n    (rst_sync),
    .slow_req (slow_req),
    .cpu_fall (cpu_fall),
    .ph2_rise (ph2_rise),
    .ph2_fall (ph2_fall),
    .rdy      (cpu_rdy),
    .leg_cyc  (leg_cyc)
  );

endmodule

// File: rtl/wsg_chk.sv
module wsg_chk (
  input logic clk,
  input logic rst_s,
  input logic cpu_clk,
  input logic phi1,
  input logic phi2,
  input logic rdy,
  input logic leg_cyc,
  input logic vda
);

  AST_CPU_TOGGLES: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> (cpu_clk != $past(cpu_clk)));  // R1

  AST_PHASE_APART: assert property (@(posedge clk) disable iff (!rst_s)
    !(phi1 && phi2));  // R2

  AST_LEG_IN_PHI2: assert property (@(posedge clk) disable iff (!rst_s)
    leg_cyc |-> phi2);  // R6

  AST_LEG_STARTS_PHI2: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(leg_cyc) |-> $rose(phi2));  // R6

  AST_RELEASE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(leg_cyc) && !leg_cyc) |-> (rdy && $fell(phi2)));  // R7

  AST_RDY_CPU_LOW: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(rdy) |-> !cpu_clk);  // R8

  AST_INVALID_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_s)
    !vda |-> rdy);  // R5

endmodule

bind wsg_top wsg_chk u_chk (
  .clk     (clk_mst),
  .rst_s   (rst_sync),
  .cpu_clk (cpu_clk),
  .phi1    (leg_phi1),
  .phi2    (leg_phi2),
  .rdy     (cpu_rdy),
  .leg_cyc (leg_cyc),
  .vda     (cpu_vda)
);

// File: tb/tb_wsg_top.sv
module tb_wsg_top;

  typedef struct packed {
    logic [7:0]  bank;
    logic [15:0] addr;
    logic        vda;
    logic        sr;
    logic [15:0] tag;
  } op_t;

  logic        clk_mst = 1'b0;
  logic        rst_n;
  logic        cfg_slow_ram;
  logic [7:0]  cpu_bank;
  logic [15:0] cpu_addr;
  logic        cpu_vda;
  logic        cpu_clk, leg_phi1, leg_phi2, cpu_rdy, leg_cyc;

  int  checks = 0;
  int  fails  = 0;
  int  k      = 0;
  bit  done   = 1'b0;

  always #5 clk_mst = ~clk_mst;

  wsg_top dut (
    .clk_mst      (clk_mst),
    .rst_n        (rst_n),
    .cfg_slow_ram (cfg_slow_ram),
    .cpu_bank     (cpu_bank),
    .cpu_addr     (cpu_addr),
    .cpu_vda      (cpu_vda),
    .cpu_clk      (cpu_clk),
    .leg_phi1     (leg_phi1),
    .leg_phi2     (leg_phi2),
    .cpu_rdy      (cpu_rdy),
    .leg_cyc      (leg_cyc)
  );

  task automatic chk(input logic [15:0] tag, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at tick %0d",
               tag, what, act, exp, k);
    end
  endtask

  // Legacy phase index after master edge t (t counted from reset release)
  function automatic int phase_of(input int t);
    return (t >= 3) ? ((t - 2) % 14) : 0;
  endfunction

  // Slow-access rule taken from R3, R4, R5
  function automatic bit is_slow(input op_t o);
    if (!o.vda) return 1'b0;
    if (o.sr)   return 1'b1;
    return (o.bank[1:0] == 2'd0) &&
           (((o.addr >= 16'h9000) && (o.addr <= 16'h9FFF)) || (o.addr >= 16'hC000));
  endfunction

  op_t q[$];

  task automatic push(input logic [7:0] b, input logic [15:0] a,
                      input logic v, input logic s, input logic [15:0] tg);
    op_t o;
    o.bank = b; o.addr = a; o.vda = v; o.sr = s; o.tag = tg;
    q.push_back(o);
  endtask

  initial begin
    repeat (200000) @(posedge clk_mst);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    op_t cur;
    bit  busy, cur_slow, prev_rdy;
    int  ta, tend, tail, c;
    logic [15:0] rtag;

    rst_n = 1'b0; cfg_slow_ram = 1'b0; cpu_bank = '0; cpu_addr = '0; cpu_vda = 1'b0;
    repeat (3) @(posedge clk_mst);
    #2;
    chk("R9", "cpu_clk in reset",  cpu_clk,  1'b0);
    chk("R9", "phi1 in reset",     leg_phi1, 1'b0);
    chk("R9", "phi2 in reset",     leg_phi2, 1'b0);
    chk("R9", "leg_cyc in reset",  leg_cyc,  1'b0);
    chk("R9", "rdy in reset",      cpu_rdy,  1'b1);

    // Stimulus list
    push(8'h00, 16'h1000, 1, 0, "R4");  // plain RAM, no waits
    push(8'h00, 16'h9000, 1, 0, "R3");  // I/O low edge
    push(8'h00, 16'h9FFF, 1, 0, "R3");  // I/O high edge
    push(8'h00, 16'hA000, 1, 0, "R3");  // just past I/O: RAM
    push(8'h00, 16'h8FFF, 1, 0, "R3");  // just below I/O: RAM
    push(8'h00, 16'hC000, 1, 0, "R3");  // ROM low edge
    push(8'h00, 16'hBFFF, 1, 0, "R3");  // just below ROM: RAM
    push(8'h00, 16'hFFFF, 1, 0, "R3");  // ROM top
    push(8'h01, 16'h9000, 1, 0, "R3");  // bank 1 is RAM
    push(8'h04, 16'h9000, 1, 0, "R3");  // bank 4 aliases bank 0
    push(8'h83, 16'hC000, 1, 0, "R3");  // aliases bank 3: RAM
    push(8'h00, 16'h9100, 0, 0, "R5");  // invalid address, I/O window
    push(8'h02, 16'h0000, 1, 1, "R4");  // slow RAM option
    push(8'h01, 16'h4000, 1, 1, "R4");
    push(8'h00, 16'h0200, 0, 1, "R5");  // invalid, slow RAM on
    push(8'h00, 16'h9004, 1, 0, "R6");  // back-to-back slow
    push(8'h00, 16'hE000, 1, 0, "R6");
    push(8'h00, 16'h0010, 1, 0, "R4");
    push(8'h00, 16'h0011, 1, 0, "R4");
    push(8'h00, 16'h0012, 1, 0, "R4");
    push(8'h00, 16'h9008, 1, 0, "R6");  // arrives on PHI2 rising edge
    push(8'h00, 16'h0013, 1, 0, "R4");
    push(8'h00, 16'h9009, 1, 0, "R6");
    push(8'h00, 16'h0014, 1, 0, "R4");
    push(8'h00, 16'h900A, 1, 0, "R6");

    @(posedge clk_mst);
    #1 rst_n = 1'b1;
    busy = 0; cur_slow = 0; prev_rdy = 1; ta = 0; tend = 0; tail = 0;
    cur = '0;

    while (tail < 30) begin
      @(posedge clk_mst);
      k++;
      #1;
      c = phase_of(k);
      // CPU model: new cycle at a CPU clock fall once the last one completed
      if (k >= 4 && (c % 2 == 0) && (!busy || k == tend)) begin
        if (q.size() > 0) begin
          cur = q.pop_front();
          cpu_bank = cur.bank; cpu_addr = cur.addr;
          cpu_vda = cur.vda;   cfg_slow_ram = cur.sr;
          busy = 1;
          cur_slow = is_slow(cur);
          ta = k + 1;
          while (phase_of(ta) != 8) ta++;
          tend = cur_slow ? (ta + 8) : (k + 2);
        end else begin
          busy = 0; cur_slow = 0;
          cpu_vda = 1'b0; cfg_slow_ram = 1'b0;
        end
      end
      if (!busy && q.size() == 0 && k > 4) tail++;
      #1;
      chk("R1", "cpu_clk", cpu_clk, logic'(c % 2));
      chk("R2", "phi1", leg_phi1, logic'(c >= 1 && c <= 6));
      chk("R2", "phi2", leg_phi2, logic'(c >= 8));
      rtag = busy ? cur.tag : 16'("R5");
      chk(rtag, "rdy", cpu_rdy, logic'(!(busy && cur_slow && k < ta + 6)));
      chk("R6", "leg_cyc", leg_cyc, logic'(busy && cur_slow && k >= ta && k < ta + 6));
      if (busy && cur_slow && k == ta + 6)
        chk("R7", "rdy back high at PHI2 fall", cpu_rdy, 1'b1);
      if (cpu_rdy !== prev_rdy)
        chk("R8", "cpu_clk low when rdy moves", cpu_clk, 1'b0);
      prev_rdy = cpu_rdy;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule